// File: doc/BRIEF.md
# Table-Driven Pulse Burst Sequencer

This block is a small synchronous state machine. After a start request it emits a burst of zero, one, two or three output pulses. The burst length is chosen by a two-bit selector input. All next-state and output decisions come from one combined lookup memory of 64 four-bit words. The words are computed at elaboration. The memory address is formed from the present state, the start line and the selector. Each data word carries the three next-state bits and an enable flag. The enable flag depends on the present state only. A state register feeds the next-state bits back to the address.

The enable flag does not leave the block directly as the pulse. It is ANDed outside the table with a clock-phase qualifier input, so the pulse width is set by that qualifier and not by the table. An active-low output-enable on the memory decides whether its data drive the loop. While the memory is disabled, its data read as all zeros. This sends the machine to idle and holds the enable flag low.

States and their codes: IDLE (000), PULSE1 (011), PULSE2 (111), PULSE3 (101) and DONE (001). Transitions:
- IDLE→IDLE while start is low.
- IDLE→DONE on start with selector 00.
- IDLE→PULSE1 on start with a nonzero selector.
- PULSE1→PULSE2 when selector bit 1 is set, else PULSE1→DONE.
- PULSE2→PULSE3 when selector bit 0 is set, else PULSE2→DONE.
- PULSE3→DONE always.
- DONE→DONE while start stays high.
- DONE→IDLE once start is low.
- Each unused code (010, 100, 110) goes to IDLE.

Top module: `burst_pulse_gen`

## Requirements
- R1: A synchronous active-high reset puts the state at 000 (IDLE). The enable flag and the pulse output are low while reset holds.
- R2: In IDLE with the memory enabled, start low keeps IDLE. Start high with selector 00 moves to DONE (001). Start high with any other selector moves to PULSE1 (011).
- R3: From PULSE1 the next state is PULSE2 (111) when selector bit 1 is 1 and DONE otherwise. The start line has no effect here.
- R4: From PULSE2 the next state is PULSE3 (101) when selector bit 0 is 1 and DONE otherwise. PULSE3 always moves to DONE.
- R5: DONE stays in DONE while start is high and returns to IDLE in the cycle after start is seen low.
- R6: The enable flag is a function of the present state. It is 1 exactly when the state is 011, 111 or 101.
- R7: The pulse output is the enable flag ANDed with the phase qualifier input. No pulse appears while the qualifier is low or outside the pulse states.
- R8: Selector values 01, 10 and 11 give exactly one, two and three enabled cycles per burst. Selector 00 gives none. Holding start high after a burst produces no second burst.
- R9: Each unused state code (010, 100, 110) maps to next state 000 with the enable flag 0, for every input combination.
- R10: While the active-low memory enable is high, the memory data read as zero. The enable flag and the pulse are low at once, and the next clock edge loads IDLE.
- R11: Memory word layout: the address is {state[2:0], start, sel[1], sel[0]} with the state in the top bits. The data word is {next_state[2:0], enable} with the enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, level sensitive |
| sel_i | input | 2 | Burst length selector |
| phase_i | input | 1 | Clock-phase qualifier for the pulse output |
| rom_oe_n_i | input | 1 | Active-low memory output enable |
| state_o | output | 3 | Present state code |
| pulse_en_o | output | 1 | Unconditional pulse enable from the memory |
| pulse_o | output | 1 | Qualified pulse output |

## Verification
The memory is swept over all 64 addresses against an arithmetic model, with output-enable both on and off. This separates the layout and branch errors from the illegal-state recovery errors. A burst is then run for each selector value with start held high for many cycles. The pulse count and the final state tell apart a wrong length, a skipped DONE state and a retrigger. Three further runs cover other cases. One changes the selector in the middle of a burst, which shows that each branch reads the selector at its own step. One holds the qualifier low, which separates the enable from the gated pulse. One drops the memory enable during a burst, which shows the forced return to IDLE.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned ST_W   = 3;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned ADDR_W = ST_W + 1 + SEL_W;
    localparam int unsigned WORD_W = ST_W + 1;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE   = 3'b000,
        ST_DONE   = 3'b001,
        ST_PULSE1 = 3'b011,
        ST_PULSE3 = 3'b101,
        ST_PULSE2 = 3'b111
    } state_t;

    // Contents of one memory word for a given address {state, start, sel}.
    function automatic logic [WORD_W-1:0] word_for(input logic [ADDR_W-1:0] a);
        state_t            ps;
        state_t            ns;
        logic              go;
        logic [SEL_W-1:0]  sel;
        logic              en;
        ps  = state_t'(a[ADDR_W-1 -: ST_W]);
        go  = a[SEL_W];
        sel = a[SEL_W-1:0];
        ns  = ST_IDLE;
        en  = 1'b0;
        unique case (ps)
            ST_IDLE: begin
                if (!go)             ns = ST_IDLE;
                else if (sel == '0)  ns = ST_DONE;
                else                 ns = ST_PULSE1;
            end
            ST_PULSE1: begin
                en = 1'b1;
                ns = sel[1] ? ST_PULSE2 : ST_DONE;
            end
            ST_PULSE2: begin
                en = 1'b1;
                ns = sel[0] ? ST_PULSE3 : ST_DONE;
            end
            ST_PULSE3: begin
                en = 1'b1;
                ns = ST_DONE;
            end
            ST_DONE: begin
                ns = go ? ST_DONE : ST_IDLE;
            end
            default: begin
                ns = ST_IDLE;
                en = 1'b0;
            end
        endcase
        return {ns, en};
    endfunction

endpackage

// File: rtl/burst_rom.sv
module burst_rom
    import burst_pkg::*;
#(
    parameter int unsigned A_W = burst_pkg::ADDR_W,
    parameter int unsigned D_W = burst_pkg::WORD_W
) (
    input  logic [A_W-1:0] addr_i,
    input  logic           oe_n_i,
    output logic [D_W-1:0] data_o
);

    localparam int unsigned DEPTH = 1 << A_W;

    logic [D_W-1:0] words [DEPTH];

    // Contents are computed per address at elaboration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = word_for(A_W'(i));
    end

    // Disabled output reads as all zeros.
    assign data_o = oe_n_i ? '0 : words[addr_i];

endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg
    import burst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t next_i,
    output state_t state_o
);

    state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= next_i;
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_pulse_gate.sv
module burst_pulse_gate (
    input  logic en_i,
    input  logic phase_i,
    output logic pulse_o
);

    assign pulse_o = en_i & phase_i;

endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
    import burst_pkg::*;
#(
    parameter int unsigned STATE_W = burst_pkg::ST_W,
    parameter int unsigned SW_W    = burst_pkg::SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [SW_W-1:0]    sel_i,
    input  logic               phase_i,
    input  logic               rom_oe_n_i,
    output logic [STATE_W-1:0] state_o,
    output logic               pulse_en_o,
    output logic               pulse_o
);

    localparam int unsigned A_W = STATE_W + 1 + SW_W;
    localparam int unsigned D_W = STATE_W + 1;

    state_t         state_q;
    state_t         next_s;
    logic           en_s;
    logic [A_W-1:0] addr_s;
    logic [D_W-1:0] word_s;

    assign addr_s = {state_q, start_i, sel_i};

    burst_rom #(.A_W(A_W), .D_W(D_W)) i_rom (
        .addr_i (addr_s),
        .oe_n_i (rom_oe_n_i),
        .data_o (word_s)
    );

    // Output process: split the word into next state and enable.
    always_comb begin
        next_s = state_t'(word_s[D_W-1:1]);
        en_s   = word_s[0];
    end

    burst_state_reg i_state (
        .clk     (clk),
        .rst     (rst),
        .next_i  (next_s),
        .state_o (state_q)
    );

    burst_pulse_gate i_gate (
        .en_i    (en_s),
        .phase_i (phase_i),
        .pulse_o (pulse_o)
    );

    assign state_o    = state_q;
    assign pulse_en_o = en_s;

endmodule

// File: rtl/burst_checker.sv
module burst_checker
    import burst_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [1:0] sel_i,
    input logic       phase_i,
    input logic       rom_oe_n_i,
    input logic [2:0] state_o,
    input logic       pulse_en_o,
    input logic       pulse_o
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state_o == ST_IDLE));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n_i && state_o == ST_IDLE && !start_i) |=> (state_o == ST_IDLE));

    p_idle_go_r2: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n_i && state_o == ST_IDLE && start_i && sel_i != 2'b00)
            |=> (state_o == ST_PULSE1));

    p_pulse1_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n_i && state_o == ST_PULSE1)
            |=> (state_o == ($past(sel_i[1]) ? ST_PULSE2 : ST_DONE)));

    p_pulse3_done_r4: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n_i && state_o == ST_PULSE3) |=> (state_o == ST_DONE));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!rom_oe_n_i && state_o == ST_DONE && start_i) |=> (state_o == ST_DONE));

    p_enable_states_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_en_o |-> (state_o == ST_PULSE1 || state_o == ST_PULSE2 ||
                        state_o == ST_PULSE3));

    p_pulse_gated_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (pulse_en_o && phase_i));

    p_legal_state_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o != 3'b010 && state_o != 3'b100 && state_o != 3'b110));

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
        rom_oe_n_i |=> (state_o == ST_IDLE));

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rom_oe_n_i |-> (!pulse_en_o && !pulse_o));

endmodule

bind burst_pulse_gen burst_checker i_burst_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sel_i      (sel_i),
    .phase_i    (phase_i),
    .rom_oe_n_i (rom_oe_n_i),
    .state_o    (state_o),
    .pulse_en_o (pulse_en_o),
    .pulse_o    (pulse_o)
);

// File: tb/test_burst_pulse_gen.sv
`timescale 1ns/1ps
module test_burst_pulse_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       phase = 1'b1;
    logic       oe_n = 1'b0;
    logic [2:0] state;
    logic       pen;
    logic       pulse;

    logic [5:0] t_addr = '0;
    logic       t_oe_n = 1'b0;
    logic [3:0] t_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_pulse_gen i_burst_pulse_gen (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .sel_i      (sel),
        .phase_i    (phase),
        .rom_oe_n_i (oe_n),
        .state_o    (state),
        .pulse_en_o (pen),
        .pulse_o    (pulse)
    );

    burst_rom i_rom_sweep (
        .addr_i (t_addr),
        .oe_n_i (t_oe_n),
        .data_o (t_data)
    );

    // Independent model of a memory word, written from the requirements.
    function automatic logic [3:0] model(input logic [5:0] a);
        logic [2:0] s;
        logic [2:0] n;
        logic       g;
        logic [1:0] w;
        s = a[5:3]; g = a[2]; w = a[1:0];
        n = 3'b000;
        if (s == 3'b000)      n = !g ? 3'b000 : (w == 2'b00 ? 3'b001 : 3'b011);
        else if (s == 3'b011) n = w[1] ? 3'b111 : 3'b001;
        else if (s == 3'b111) n = w[0] ? 3'b101 : 3'b001;
        else if (s == 3'b101) n = 3'b001;
        else if (s == 3'b001) n = g ? 3'b001 : 3'b000;
        return {n, (s == 3'b011 || s == 3'b111 || s == 3'b101)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Runs a burst with start held high; returns enable and pulse counts.
    task automatic burst(input logic [1:0] code, output int n_en, output int n_pl);
        n_en = 0; n_pl = 0;
        sel = code; start = 1'b1;
        for (int k = 0; k < 12; k++) begin
            tick();
            n_en += int'(pen);
            n_pl += int'(pulse);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ne, np;
        // R11 / R9 / R6: exhaustive memory sweep
        for (int a = 0; a < 64; a++) begin
            t_addr = 6'(a); t_oe_n = 1'b0;
            #1;
            if (a[5:3] == 3'b010 || a[5:3] == 3'b100 || a[5:3] == 3'b110)
                check("R9 unused state word", int'(t_data), 0);
            else
                check("R11 word layout", int'(t_data), int'(model(6'(a))));
            t_oe_n = 1'b1;
            #1;
            check("R10 disabled word", int'(t_data), 0);
        end

        // R1 reset
        tick(); tick(); tick();
        check("R1 reset state", int'(state), 0);
        check("R1 reset enable", int'(pen), 0);
        check("R1 reset pulse", int'(pulse), 0);
        rst = 1'b0;

        // R2 idle hold
        for (int k = 0; k < 4; k++) tick();
        check("R2 idle hold", int'(state), 0);

        // R2 first step and R8 bursts for every selector value
        for (int c = 0; c < 4; c++) begin
            sel = 2'(c); start = 1'b1;
            tick();
            check("R2 first step", int'(state), (c == 0) ? 1 : 3);
            ne = int'(pen); np = int'(pulse);
            for (int k = 0; k < 11; k++) begin
                tick();
                ne += int'(pen); np += int'(pulse);
            end
            check("R8 enabled cycles", ne, c);
            check("R7 pulse cycles with qualifier high", np, c);
            check("R5 held in DONE, no retrigger", int'(state), 1);
            start = 1'b0;
            tick();
            check("R5 return to IDLE", int'(state), 0);
        end

        // R3 / R4: selector changed during a burst
        sel = 2'b01; start = 1'b1;
        tick();
        check("R3 enter PULSE1", int'(state), 3);
        sel = 2'b10; start = 1'b0;
        tick();
        check("R3 branch on bit 1 to PULSE2", int'(state), 7);
        check("R6 enable in PULSE2", int'(pen), 1);
        tick();
        check("R4 bit 0 low ends burst", int'(state), 1);
        check("R6 enable off in DONE", int'(pen), 0);
        tick();
        check("R5 DONE to IDLE", int'(state), 0);

        // R3: PULSE1 ends when selector bit 1 is low, start ignored
        sel = 2'b01; start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        check("R3 PULSE1 to DONE", int'(state), 1);
        tick();

        // R7: qualifier low suppresses the pulse but not the enable
        phase = 1'b0;
        burst(2'b11, ne, np);
        check("R7 enable cycles with qualifier low", ne, 3);
        check("R7 no pulse with qualifier low", np, 0);
        start = 1'b0; phase = 1'b1;
        tick();

        // R10: memory disabled during a burst
        sel = 2'b11; start = 1'b1;
        tick();
        check("R10 burst started", int'(state), 3);
        oe_n = 1'b1; start = 1'b0;
        #1;
        check("R10 enable forced low", int'(pen), 0);
        check("R10 pulse forced low", int'(pulse), 0);
        tick();
        check("R10 forced to IDLE", int'(state), 0);
        start = 1'b1;
        tick();
        check("R10 start ignored while disabled", int'(state), 0);
        start = 1'b0; oe_n = 1'b0;
        tick();
        check("R2 idle after re-enable", int'(state), 0);

        // R1: reset in the middle of a burst
        sel = 2'b11; start = 1'b1;
        tick(); tick();
        rst = 1'b1;
        tick();
        check("R1 reset mid-burst", int'(state), 0);
        check("R1 enable low after reset", int'(pen), 0);
        rst = 1'b0; start = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule